// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is a synthesizable model of a parallel NOR flash device that is driven by single-byte commands written over a simple synchronous memory bus. It holds a small word-wide storage array split into equal sectors. A multi-cycle command sequencer decides what a read returns. Depending on the last accepted command, a read at a given address returns the stored word, the 8-bit status register, or one byte of a parameter query table.

Software erases a sector by writing a setup code and then a confirm code. It programs a run of words with a buffered sequence: a start code, a word count, the data writes, and a confirm. It can also read or clear the status register, enter query mode, and acknowledge lock or unlock requests. Program and erase complete at once, with no busy time. All reads, writes and sector offsets use byte addresses. Bus accesses are full words aligned to the bus width.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset the block is in read-array mode, every stored word reads as all ones, the status register holds 0x80 and `rd_data` is zero.
- R2: `rd_data` takes its new value at the clock edge that samples `rd_en` high, and holds its value in every cycle that `rd_en` is low.
- R3: A write of 0x20 followed by a write of 0xD0 erases the sector containing the 0xD0 write address to all ones. Other sectors are left unchanged. Status bit 7 is set, and later reads return the status register until another command is written.
- R4: After 0x20, any write other than 0xD0 cancels the erase. The data is unchanged and the block returns to read-array mode.
- R5: A write of 0xE8 starts a buffered program and sets status bit 7. The next write's low byte is the word count minus one. That many plus one data writes follow, each storing the full write word at its address. A 0xD0 write then returns the block to read-array mode.
- R6: In a buffered program, a data write outside the sector of the first data write is not stored and sets status bit 4. The sequence still counts it and still ends in read-array mode.
- R7: After 0x70, and while an erase, lock or buffered sequence waits for its next write, reads return the status register zero-extended in the low byte.
- R8: A write of 0x50 clears the status register to 0x00 and selects read-array mode.
- R9: After 0x98, a read returns the query byte at index (byte address >> log2(bus bytes)), zero-extended. The table holds Q, R, Y at 0x10 to 0x12 and 0x01 at 0x13. It holds log2 of the total byte size at 0x27 and 0x01 at 0x2C. It holds the sector count minus one at 0x2D/0x2E and the sector size divided by 256 at 0x2F/0x30, each as a little-endian 16-bit value. An index at or beyond the table length returns zero.
- R10: A write of 0x60 followed by 0xD0 or 0x01 sets status bit 7, leaves the data unchanged and returns to read-array mode.
- R11: A write of 0xFF in any state except the buffered data phase, or an unrecognised command, returns the block to read-array mode with no operation pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (10) | Byte address shared by reads and writes |
| wr_en | input | 1 | Write strobe; the low byte of `wr_data` is the command |
| wr_data | input | 8*BUS_BYTES (16) | Write word |
| rd_en | input | 1 | Read strobe; `rd_data` is valid one clock later |
| rd_data | output | 8*BUS_BYTES (16) | Registered read word |

## Verification
The bench uses the default build: a 16-bit bus, with four sectors of 256 bytes. With this build, query indices are the byte address shifted right by one. The sector boundary at 0x100 lets an erase be checked against an untouched neighbour. The erase-region and size fields take small, distinct values (3, 1 and 10), so a swapped or misplaced field shows up. The same build lets a buffered program run across a sector boundary at 0x300, which exercises the error bit.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;

   typedef enum logic [2:0] {
      M_ARRAY    = 3'd0,
      M_STATUS   = 3'd1,
      M_QUERY    = 3'd2,
      M_ERASE_CF = 3'd3,
      M_LOCK_CF  = 3'd4,
      M_BUF_CNT  = 3'd5,
      M_BUF_DATA = 3'd6,
      M_BUF_CF   = 3'd7
   } nfc_mode_e;

   localparam logic [7:0] OP_ERASE   = 8'h20;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_BUFPROG = 8'hE8;
   localparam logic [7:0] OP_STAT    = 8'h70;
   localparam logic [7:0] OP_CLEAR   = 8'h50;
   localparam logic [7:0] OP_QUERY   = 8'h98;
   localparam logic [7:0] OP_LOCK    = 8'h60;
   localparam logic [7:0] OP_LOCKALT = 8'h01;
   localparam logic [7:0] OP_ARRAY   = 8'hFF;

   localparam int RDY_BIT = 7;
   localparam int ERR_BIT = 4;

endpackage

// File: rtl/nfc_seq.sv
`timescale 1ns/1ps
module nfc_seq
   import nfc_pkg::*;
#(
   parameter int SW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    cmd,
   input  logic [SW-1:0] wsect,
   output nfc_mode_e     mode,
   output logic [7:0]    status,
   output logic          prog_en,
   output logic          erase_en
);

   nfc_mode_e     mode_q, mode_d;
   logic [7:0]    stat_q, stat_d;
   logic [7:0]    cnt_q, cnt_d;
   logic [SW-1:0] bsect_q, bsect_d;
   logic          first_q, first_d;

   always_comb begin
      mode_d   = mode_q;
      stat_d   = stat_q;
      cnt_d    = cnt_q;
      bsect_d  = bsect_q;
      first_d  = first_q;
      prog_en  = 1'b0;
      erase_en = 1'b0;
      if (wr_en) begin
         case (mode_q)
            M_ARRAY, M_STATUS, M_QUERY: begin
               case (cmd)
                  OP_ERASE:   mode_d = M_ERASE_CF;
                  OP_BUFPROG: begin
                     mode_d = M_BUF_CNT;
                     stat_d[RDY_BIT] = 1'b1;
                  end
                  OP_STAT:    mode_d = M_STATUS;
                  OP_CLEAR: begin
                     stat_d = 8'h00;
                     mode_d = M_ARRAY;
                  end
                  OP_QUERY:   mode_d = M_QUERY;
                  OP_LOCK:    mode_d = M_LOCK_CF;
                  default:    mode_d = M_ARRAY;
               endcase
            end
            M_ERASE_CF: begin
               if (cmd == OP_CONFIRM) begin
                  erase_en = 1'b1;
                  stat_d[RDY_BIT] = 1'b1;
                  mode_d = M_STATUS;
               end else begin
                  mode_d = M_ARRAY;
               end
            end
            M_LOCK_CF: begin
               if (cmd == OP_CONFIRM || cmd == OP_LOCKALT)
                  stat_d[RDY_BIT] = 1'b1;
               mode_d = M_ARRAY;
            end
            M_BUF_CNT: begin
               if (cmd == OP_ARRAY) begin
                  mode_d = M_ARRAY;
               end else begin
                  cnt_d   = cmd;
                  first_d = 1'b1;
                  mode_d  = M_BUF_DATA;
               end
            end
            M_BUF_DATA: begin
               if (first_q || wsect == bsect_q)
                  prog_en = 1'b1;
               else
                  stat_d[ERR_BIT] = 1'b1;
               if (first_q) begin
                  bsect_d = wsect;
                  first_d = 1'b0;
               end
               if (cnt_q == 8'd0)
                  mode_d = M_BUF_CF;
               else
                  cnt_d = cnt_q - 8'd1;
            end
            M_BUF_CF: begin
               if (cmd == OP_CONFIRM)
                  stat_d[RDY_BIT] = 1'b1;
               mode_d = M_ARRAY;
            end
            default: mode_d = M_ARRAY;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= M_ARRAY;
         stat_q  <= 8'h80;
         cnt_q   <= 8'd0;
         bsect_q <= '0;
         first_q <= 1'b0;
      end else begin
         mode_q  <= mode_d;
         stat_q  <= stat_d;
         cnt_q   <= cnt_d;
         bsect_q <= bsect_d;
         first_q <= first_d;
      end
   end

   assign mode   = mode_q;
   assign status = stat_q;

   p_erase_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode_q == M_ERASE_CF && cmd == OP_CONFIRM) |=> (stat_q[RDY_BIT] && mode_q == M_STATUS));

   p_erase_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode_q == M_ERASE_CF && cmd != OP_CONFIRM) |=> (mode_q == M_ARRAY));

   p_sector_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode_q == M_BUF_DATA && !first_q && wsect != bsect_q) |=> stat_q[ERR_BIT]);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cmd == OP_CLEAR && (mode_q == M_ARRAY || mode_q == M_STATUS || mode_q == M_QUERY))
      |=> (stat_q == 8'h00 && mode_q == M_ARRAY));

   p_lock_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode_q == M_LOCK_CF && (cmd == OP_CONFIRM || cmd == OP_LOCKALT))
      |=> (stat_q[RDY_BIT] && mode_q == M_ARRAY));

   p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cmd == OP_ARRAY && mode_q != M_BUF_DATA) |=> (mode_q == M_ARRAY));

   p_erase_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_en && erase_en));

endmodule

// File: rtl/nfc_store.sv
`timescale 1ns/1ps
module nfc_store #(
   parameter int DATA_W     = 16,
   parameter int WORDS      = 512,
   parameter int SECT_WORDS = 128,
   parameter int WA         = 9,
   parameter int SW         = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic              erase_en,
   input  logic [WA-1:0]     waddr,
   input  logic [SW-1:0]     esect,
   input  logic [DATA_W-1:0] wdata,
   input  logic [WA-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] words [WORDS];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      localparam logic [SW-1:0] G_SECT = SW'(g / SECT_WORDS);
      localparam logic [WA-1:0] G_ADDR = WA'(g);
      logic [DATA_W-1:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '1;
         else if (erase_en && esect == G_SECT)
            word_q <= '1;
         else if (prog_en && waddr == G_ADDR)
            word_q <= wdata;
      end

      assign words[g] = word_q;
   end

   assign rdata = words[raddr];

   p_prog_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_en && !erase_en) |=> (words[$past(waddr)] == $past(wdata)));

   p_erase_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_en && waddr[WA-1 -: SW] == esect) |=> (words[$past(waddr)] == '1));

endmodule

// File: rtl/nfc_query_rom.sv
`timescale 1ns/1ps
module nfc_query_rom #(
   parameter int IDX_W        = 9,
   parameter int TOTAL_LOG2   = 10,
   parameter int NUM_SECTORS  = 4,
   parameter int SECTOR_BYTES = 256,
   parameter int QRY_LEN      = 49
) (
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       qbyte
);

   localparam logic [15:0] REG_COUNT = 16'(NUM_SECTORS - 1);
   localparam logic [15:0] REG_SIZE  = 16'(SECTOR_BYTES / 256);
   localparam logic [7:0]  SIZE_CODE = 8'(TOTAL_LOG2);
   localparam int          LOW_W     = (IDX_W < 8) ? IDX_W : 8;

   logic [7:0] low_idx;

   assign low_idx = 8'(idx[LOW_W-1:0]);

   always_comb begin
      qbyte = 8'h00;
      if (32'(idx) < QRY_LEN) begin
         case (low_idx)
            8'h10: qbyte = 8'h51;
            8'h11: qbyte = 8'h52;
            8'h12: qbyte = 8'h59;
            8'h13: qbyte = 8'h01;
            8'h27: qbyte = SIZE_CODE;
            8'h2C: qbyte = 8'h01;
            8'h2D: qbyte = REG_COUNT[7:0];
            8'h2E: qbyte = REG_COUNT[15:8];
            8'h2F: qbyte = REG_SIZE[7:0];
            8'h30: qbyte = REG_SIZE[15:8];
            default: qbyte = 8'h00;
         endcase
      end
   end

endmodule

// File: rtl/nor_cmd_flash.sv
`timescale 1ns/1ps
module nor_cmd_flash
   import nfc_pkg::*;
#(
   parameter int BUS_BYTES    = 2,
   parameter int SECTOR_BYTES = 256,
   parameter int NUM_SECTORS  = 4,
   parameter int QRY_LEN      = 49,
   localparam int DATA_W      = 8 * BUS_BYTES,
   localparam int TOTAL_BYTES = SECTOR_BYTES * NUM_SECTORS,
   localparam int ADDR_W      = $clog2(TOTAL_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data
);

   localparam int LANE_W     = $clog2(BUS_BYTES);
   localparam int WA         = ADDR_W - LANE_W;
   localparam int WORDS      = TOTAL_BYTES / BUS_BYTES;
   localparam int SECT_W     = $clog2(SECTOR_BYTES);
   localparam int SW         = ADDR_W - SECT_W;
   localparam int SECT_WORDS = SECTOR_BYTES / BUS_BYTES;

   if (!(BUS_BYTES == 1 || BUS_BYTES == 2 || BUS_BYTES == 4)) begin : g_bad_bus
      $error("BUS_BYTES must be 1, 2 or 4");
   end
   if (SECTOR_BYTES < 256 || (1 << SECT_W) != SECTOR_BYTES) begin : g_bad_sect
      $error("SECTOR_BYTES must be a power of two of at least 256");
   end
   if (NUM_SECTORS < 2 || (1 << SW) != NUM_SECTORS) begin : g_bad_count
      $error("NUM_SECTORS must be a power of two of at least 2");
   end
   if (QRY_LEN < 1 || QRY_LEN > 256) begin : g_bad_qlen
      $error("QRY_LEN must lie in 1..256");
   end

   nfc_mode_e         mode;
   logic [7:0]        status;
   logic              prog_en;
   logic              erase_en;
   logic [WA-1:0]     word_addr;
   logic [SW-1:0]     sect;
   logic [WA-1:0]     qidx;
   logic [7:0]        qbyte;
   logic [DATA_W-1:0] arr_word;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] qry_word;
   logic [DATA_W-1:0] rd_sel;
   logic [DATA_W-1:0] rd_q;

   assign word_addr = addr[ADDR_W-1:LANE_W];
   assign sect      = addr[ADDR_W-1:SECT_W];
   assign qidx      = addr[ADDR_W-1:LANE_W];

   nfc_seq #(.SW(SW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .cmd      (wr_data[7:0]),
      .wsect    (sect),
      .mode     (mode),
      .status   (status),
      .prog_en  (prog_en),
      .erase_en (erase_en)
   );

   nfc_store #(
      .DATA_W     (DATA_W),
      .WORDS      (WORDS),
      .SECT_WORDS (SECT_WORDS),
      .WA         (WA),
      .SW         (SW)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog_en  (prog_en),
      .erase_en (erase_en),
      .waddr    (word_addr),
      .esect    (sect),
      .wdata    (wr_data),
      .raddr    (word_addr),
      .rdata    (arr_word)
   );

   nfc_query_rom #(
      .IDX_W        (WA),
      .TOTAL_LOG2   (ADDR_W),
      .NUM_SECTORS  (NUM_SECTORS),
      .SECTOR_BYTES (SECTOR_BYTES),
      .QRY_LEN      (QRY_LEN)
   ) u_rom (
      .idx   (qidx),
      .qbyte (qbyte)
   );

   if (DATA_W == 8) begin : g_narrow
      assign stat_word = status;
      assign qry_word  = qbyte;
   end else begin : g_wide
      assign stat_word = {{(DATA_W-8){1'b0}}, status};
      assign qry_word  = {{(DATA_W-8){1'b0}}, qbyte};
   end

   always_comb begin
      case (mode)
         M_ARRAY: rd_sel = arr_word;
         M_QUERY: rd_sel = qry_word;
         default: rd_sel = stat_word;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_q <= '0;
      else if (rd_en)
         rd_q <= rd_sel;
   end

   assign rd_data = rd_q;

   p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   p_query_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && mode == M_QUERY && 32'(qidx) >= QRY_LEN) |=> (rd_data == '0));

   p_status_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && mode == M_STATUS) |=> (rd_data[DATA_W-1:8] == '0));

endmodule

// File: tb/nor_cmd_flash_tb.sv
`timescale 1ns/1ps
module nor_cmd_flash_tb;

   typedef struct packed {
      logic        is_rd;
      logic [9:0]  a;
      logic [15:0] d;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 65;
   // Tags per entry: R1 reset view, R7 status view, R11 abort, R5 program,
   // R9 query, R3 erase, R4 erase cancel, R8 clear, R10 lock, R6 sector error.
   localparam vec_t VEC [NV] = '{
      '{1'b1, 10'h000, 16'hFFFF, 8'd1},
      '{1'b1, 10'h3FE, 16'hFFFF, 8'd1},
      '{1'b0, 10'h000, 16'h0070, 8'd7},
      '{1'b1, 10'h000, 16'h0080, 8'd7},
      '{1'b0, 10'h000, 16'h00FF, 8'd11},
      '{1'b1, 10'h000, 16'hFFFF, 8'd11},
      '{1'b0, 10'h010, 16'h00E8, 8'd5},
      '{1'b1, 10'h010, 16'h0080, 8'd7},
      '{1'b0, 10'h010, 16'h0001, 8'd5},
      '{1'b0, 10'h010, 16'h1234, 8'd5},
      '{1'b0, 10'h012, 16'hABCD, 8'd5},
      '{1'b0, 10'h010, 16'h00D0, 8'd5},
      '{1'b1, 10'h010, 16'h1234, 8'd5},
      '{1'b1, 10'h012, 16'hABCD, 8'd5},
      '{1'b0, 10'h100, 16'h00E8, 8'd5},
      '{1'b0, 10'h100, 16'h0000, 8'd5},
      '{1'b0, 10'h100, 16'h5A5A, 8'd5},
      '{1'b0, 10'h100, 16'h00D0, 8'd5},
      '{1'b1, 10'h100, 16'h5A5A, 8'd5},
      '{1'b0, 10'h000, 16'h0098, 8'd9},
      '{1'b1, 10'h020, 16'h0051, 8'd9},
      '{1'b1, 10'h022, 16'h0052, 8'd9},
      '{1'b1, 10'h024, 16'h0059, 8'd9},
      '{1'b1, 10'h04E, 16'h000A, 8'd9},
      '{1'b1, 10'h05A, 16'h0003, 8'd9},
      '{1'b1, 10'h05E, 16'h0001, 8'd9},
      '{1'b1, 10'h062, 16'h0000, 8'd9},
      '{1'b0, 10'h000, 16'h00FF, 8'd11},
      '{1'b1, 10'h010, 16'h1234, 8'd11},
      '{1'b0, 10'h010, 16'h0020, 8'd7},
      '{1'b1, 10'h010, 16'h0080, 8'd7},
      '{1'b0, 10'h010, 16'h00D0, 8'd3},
      '{1'b1, 10'h010, 16'h0080, 8'd3},
      '{1'b0, 10'h000, 16'h00FF, 8'd3},
      '{1'b1, 10'h010, 16'hFFFF, 8'd3},
      '{1'b1, 10'h012, 16'hFFFF, 8'd3},
      '{1'b1, 10'h100, 16'h5A5A, 8'd3},
      '{1'b0, 10'h100, 16'h0020, 8'd4},
      '{1'b0, 10'h100, 16'h0055, 8'd4},
      '{1'b1, 10'h100, 16'h5A5A, 8'd4},
      '{1'b0, 10'h000, 16'h0050, 8'd8},
      '{1'b1, 10'h100, 16'h5A5A, 8'd8},
      '{1'b0, 10'h000, 16'h0070, 8'd8},
      '{1'b1, 10'h000, 16'h0000, 8'd8},
      '{1'b0, 10'h000, 16'h0060, 8'd10},
      '{1'b1, 10'h000, 16'h0000, 8'd7},
      '{1'b0, 10'h000, 16'h00D0, 8'd10},
      '{1'b1, 10'h100, 16'h5A5A, 8'd10},
      '{1'b0, 10'h000, 16'h0070, 8'd10},
      '{1'b1, 10'h000, 16'h0080, 8'd10},
      '{1'b0, 10'h000, 16'h0050, 8'd6},
      '{1'b0, 10'h200, 16'h00E8, 8'd6},
      '{1'b0, 10'h200, 16'h0001, 8'd6},
      '{1'b0, 10'h200, 16'h1111, 8'd6},
      '{1'b0, 10'h300, 16'h2222, 8'd6},
      '{1'b0, 10'h000, 16'h00D0, 8'd6},
      '{1'b1, 10'h300, 16'hFFFF, 8'd6},
      '{1'b1, 10'h200, 16'h1111, 8'd6},
      '{1'b0, 10'h000, 16'h0070, 8'd6},
      '{1'b1, 10'h000, 16'h0090, 8'd6},
      '{1'b0, 10'h000, 16'h0042, 8'd11},
      '{1'b1, 10'h200, 16'h1111, 8'd11},
      '{1'b0, 10'h000, 16'h0060, 8'd10},
      '{1'b0, 10'h000, 16'h0001, 8'd10},
      '{1'b1, 10'h200, 16'h1111, 8'd10}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [15:0] rd_data;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   nor_cmd_flash u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (rd_data)
   );

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [9:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [9:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   initial begin : watchdog
      #(4 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [15:0] got;
      repeat (3) @(negedge clk);
      check("R1 rd_data in reset", rd_data, 16'h0000);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].is_rd) begin
            bus_rd(VEC[i].a, got);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), got, VEC[i].d);
         end else begin
            bus_wr(VEC[i].a, VEC[i].d);
         end
      end

      // R2: value changes only at the edge that samples rd_en
      @(negedge clk);
      addr = 10'h100; rd_en = 1'b1;
      #0.5;
      check("R2 before edge", rd_data, 16'h1111);
      @(negedge clk);
      rd_en = 1'b0;
      check("R2 after edge", rd_data, 16'h5A5A);
      addr = 10'h200;
      @(negedge clk);
      check("R2 hold without strobe", rd_data, 16'h5A5A);

      // R1: reset mid-run restores blank array and ready status
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 rd_data cleared", rd_data, 16'h0000);
      rst_n = 1'b1;
      bus_rd(10'h200, got);
      check("R1 array blank after reset", got, 16'hFFFF);
      bus_wr(10'h000, 16'h0070);
      bus_rd(10'h000, got);
      check("R1 status after reset", got, 16'h0080);

      // R11: 0xFF while the count is awaited cancels the program
      bus_wr(10'h200, 16'h00E8);
      bus_wr(10'h200, 16'h00FF);
      bus_wr(10'h200, 16'h7777);
      bus_rd(10'h200, got);
      check("R11 abort before count", got, 16'hFFFF);

      // R5: data phase takes 0x00FF as data, one word count
      bus_wr(10'h3F0, 16'h00E8);
      bus_wr(10'h3F0, 16'h0000);
      bus_wr(10'h3F0, 16'h00FF);
      bus_wr(10'h3F0, 16'h00D0);
      bus_rd(10'h3F0, got);
      check("R5 data word equal to abort code", got, 16'h00FF);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule